// File: doc/BRIEF.md
# Lane Loopback and Broadcast Routing Matrix

This block sits beside the per-lane receive and transmit paths of a four-lane redriver and decides, for every lane pair, which receive stream feeds each of the two transmit outputs. A lane pair has an A channel and a B channel. With the pair's loopback bit high, each channel simply repeats its own receive data. With the bit low, the A receive stream is steered to both transmitters. Turning off one input or one output then narrows that broadcast to a demux or mux path.

Each transmit output carries an enable as well as its data bit. The enable drops when the transmitting channel is powered down or has its output switched off. It also drops when the receive channel it would repeat is powered down, has its input switched off, or reports no valid signal (squelch). Data is modelled as one bit per channel per clock. All outputs are registered. A strap input fills all four loopback bits while reset is held, and a load strobe rewrites them afterwards.

Top module: `lane_xbar`

## Requirements
- R1: While `rstN` is low at a rising edge, every `txA`, `txB`, `txEnA` and `txEnB` bit becomes 0 and every `passThru` bit takes the value of `lbStrapN` (1 = pass-through, 0 = loopback).
- R2: In a lane whose `passThru` bit is 1, an enabled `txA` carries `rxA` and an enabled `txB` carries `rxB`, one edge after the inputs are applied.
- R3: In a lane whose `passThru` bit is 0 and whose `inDisA` is 0, both enabled transmit outputs carry `rxA` (broadcast).
- R4: In loopback with `outDisA` = 1 (demux), `txEnA` is 0 and `txB` still carries `rxA`.
- R5: In loopback with `inDisA` = 1 (mux), `txB` carries `rxB` and `txEnA` is 0, because A's selected source is off.
- R6: A channel with `outDis` = 1 has its transmit enable at 0 on the next edge, whatever its source.
- R7: When the selected source channel has `sig` = 0, the transmit enable fed from it is 0 on the next edge.
- R8: When the selected source channel has `inDis` = 1, the transmit enable fed from it is 0 on the next edge.
- R9: A channel with `pwrDnN` = 0 has its own transmit enable at 0, and its receive stream counts as absent for any output that selects it.
- R10: A rising edge with `lbLoad` = 1 (and `rstN` high) copies `lbValue` into `passThru`. The new routing applies to outputs produced from the following edge on.
- R11: Whenever a transmit enable is 0, the matching transmit data bit is 0.
- R12: Each lane's outputs depend only on that lane's own inputs and loopback bit; lanes with different settings do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lbStrapN | input | 1 | Loopback strap loaded into all lanes during reset (0 = loopback) |
| lbLoad | input | 1 | Strobe that writes `lbValue` into the loopback bits |
| lbValue | input | LANES | New per-lane loopback bits (1 = pass-through) |
| rxA | input | LANES | A channel receive data bits |
| rxB | input | LANES | B channel receive data bits |
| sigA | input | LANES | A channel signal-detect (1 = valid input) |
| sigB | input | LANES | B channel signal-detect (1 = valid input) |
| inDisA | input | LANES | A channel input off when 1 |
| inDisB | input | LANES | B channel input off when 1 |
| outDisA | input | LANES | A channel output off when 1 |
| outDisB | input | LANES | B channel output off when 1 |
| pwrDnNA | input | LANES | A channel powered down when 0 |
| pwrDnNB | input | LANES | B channel powered down when 0 |
| txA | output | LANES | A channel transmit data |
| txB | output | LANES | B channel transmit data |
| txEnA | output | LANES | A channel transmit enable (0 = high-impedance or squelched) |
| txEnB | output | LANES | B channel transmit enable (0 = high-impedance or squelched) |
| passThru | output | LANES | Current per-lane loopback bits (1 = pass-through) |

## Verification
Data, enable and gating inputs reach the transmit outputs one rising edge after they are applied. A write of `lbValue` appears on `passThru` after one edge, but it steers data only in results produced from the edge after that. The bench drives every stimulus on a falling edge. In the same step it computes the expected outputs from its own model, using the loopback state that was in force before the write, and tags the entry with the cycle number at which it is due. A monitor runs on falling edges and pops an entry only when the cycle counter reaches that number, so each result is compared exactly one edge after its stimulus.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;

  // Per-lane strobes passed from the routing control to the datapath.
  typedef struct packed {
    logic bTakesA;  // B transmitter repeats the A receive stream
    logic srcAOk;   // source feeding the A transmitter is present
    logic srcBOk;   // source feeding the B transmitter is present
    logic drvAOk;   // A transmitter itself is allowed to drive
    logic drvBOk;   // B transmitter itself is allowed to drive
  } laneStrobe_t;

endpackage

// File: rtl/lane_xbar_ctrl.sv
module lane_xbar_ctrl
  import lane_xbar_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lbStrapN,
  input  logic             lbLoad,
  input  logic [LANES-1:0] lbValue,
  input  logic [LANES-1:0] sigA,
  input  logic [LANES-1:0] sigB,
  input  logic [LANES-1:0] inDisA,
  input  logic [LANES-1:0] inDisB,
  input  logic [LANES-1:0] outDisA,
  input  logic [LANES-1:0] outDisB,
  input  logic [LANES-1:0] pwrDnNA,
  input  logic [LANES-1:0] pwrDnNB,
  output logic [LANES-1:0] passThru,
  output laneStrobe_t      strobes [LANES]
);

  logic [LANES-1:0] loopReg;

  // Loopback bits: strap during reset, explicit load afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopReg <= {LANES{lbStrapN}};
    end else if (lbLoad) begin
      loopReg <= lbValue;
    end
  end

  assign passThru = loopReg;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic availA;
    logic availB;
    logic crossOn;

    // A receive stream is usable only if powered, input on and signal valid.
    assign availA  = pwrDnNA[ln] & ~inDisA[ln] & sigA[ln];
    assign availB  = pwrDnNB[ln] & ~inDisB[ln] & sigB[ln];
    // Loopback steers A receive to B transmit unless A's input is off (mux).
    assign crossOn = ~loopReg[ln] & ~inDisA[ln];

    always_comb begin
      strobes[ln].bTakesA = crossOn;
      strobes[ln].srcAOk  = availA;
      strobes[ln].srcBOk  = crossOn ? availA : availB;
      strobes[ln].drvAOk  = pwrDnNA[ln] & ~outDisA[ln];
      strobes[ln].drvBOk  = pwrDnNB[ln] & ~outDisB[ln];
    end
  end

endmodule

// File: rtl/lane_xbar_dp.sv
module lane_xbar_dp
  import lane_xbar_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] rxA,
  input  logic [LANES-1:0] rxB,
  input  laneStrobe_t      strobes [LANES],
  output logic [LANES-1:0] txA,
  output logic [LANES-1:0] txB,
  output logic [LANES-1:0] txEnA,
  output logic [LANES-1:0] txEnB
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic enANext;
    logic enBNext;
    logic srcBBit;

    assign enANext = strobes[ln].drvAOk & strobes[ln].srcAOk;
    assign enBNext = strobes[ln].drvBOk & strobes[ln].srcBOk;
    assign srcBBit = strobes[ln].bTakesA ? rxA[ln] : rxB[ln];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txA[ln]   <= 1'b0;
        txB[ln]   <= 1'b0;
        txEnA[ln] <= 1'b0;
        txEnB[ln] <= 1'b0;
      end else begin
        txEnA[ln] <= enANext;
        txEnB[ln] <= enBNext;
        txA[ln]   <= enANext & rxA[ln];
        txB[ln]   <= enBNext & srcBBit;
      end
    end
  end

endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
  import lane_xbar_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lbStrapN,
  input  logic             lbLoad,
  input  logic [LANES-1:0] lbValue,
  input  logic [LANES-1:0] rxA,
  input  logic [LANES-1:0] rxB,
  input  logic [LANES-1:0] sigA,
  input  logic [LANES-1:0] sigB,
  input  logic [LANES-1:0] inDisA,
  input  logic [LANES-1:0] inDisB,
  input  logic [LANES-1:0] outDisA,
  input  logic [LANES-1:0] outDisB,
  input  logic [LANES-1:0] pwrDnNA,
  input  logic [LANES-1:0] pwrDnNB,
  output logic [LANES-1:0] txA,
  output logic [LANES-1:0] txB,
  output logic [LANES-1:0] txEnA,
  output logic [LANES-1:0] txEnB,
  output logic [LANES-1:0] passThru
);

  laneStrobe_t strobes [LANES];

  lane_xbar_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lbStrapN (lbStrapN),
    .lbLoad   (lbLoad),
    .lbValue  (lbValue),
    .sigA     (sigA),
    .sigB     (sigB),
    .inDisA   (inDisA),
    .inDisB   (inDisB),
    .outDisA  (outDisA),
    .outDisB  (outDisB),
    .pwrDnNA  (pwrDnNA),
    .pwrDnNB  (pwrDnNB),
    .passThru (passThru),
    .strobes  (strobes)
  );

  lane_xbar_dp #(.LANES(LANES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxA     (rxA),
    .rxB     (rxB),
    .strobes (strobes),
    .txA     (txA),
    .txB     (txB),
    .txEnA   (txEnA),
    .txEnB   (txEnB)
  );

endmodule

// File: rtl/lane_xbar_chk.sv
module lane_xbar_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lbStrapN,
  input logic             lbLoad,
  input logic [LANES-1:0] lbValue,
  input logic [LANES-1:0] rxA,
  input logic [LANES-1:0] rxB,
  input logic [LANES-1:0] sigB,
  input logic [LANES-1:0] inDisA,
  input logic [LANES-1:0] outDisA,
  input logic [LANES-1:0] outDisB,
  input logic [LANES-1:0] pwrDnNA,
  input logic [LANES-1:0] txA,
  input logic [LANES-1:0] txB,
  input logic [LANES-1:0] txEnA,
  input logic [LANES-1:0] txEnB,
  input logic [LANES-1:0] passThru
);

  a_r1_strap_load: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> passThru == {LANES{$past(lbStrapN)}});

  a_r10_lb_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(lbLoad) |-> passThru == $past(lbValue));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    a_r2_normal_a: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $past(passThru[i]) && txEnA[i] |-> txA[i] == $past(rxA[i]));

    a_r3_broadcast_b: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && !$past(passThru[i]) && !$past(inDisA[i]) && txEnB[i]
      |-> txB[i] == $past(rxA[i]));

    a_r5_mux_b: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && !$past(passThru[i]) && $past(inDisA[i]) && txEnB[i]
      |-> txB[i] == $past(rxB[i]));

    a_r6_outdis_a: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $past(outDisA[i]) |-> !txEnA[i]);

    a_r6_outdis_b: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $past(outDisB[i]) |-> !txEnB[i]);

    a_r7_squelch_b: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $past(passThru[i]) && !$past(sigB[i]) |-> !txEnB[i]);

    a_r9_pwrdn_a: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && !$past(pwrDnNA[i]) |-> !txEnA[i]);

    a_r11_quiet_a: assert property (@(posedge clk) disable iff (!rstN)
      !txEnA[i] |-> !txA[i]);

    a_r11_quiet_b: assert property (@(posedge clk) disable iff (!rstN)
      !txEnB[i] |-> !txB[i]);
  end

endmodule

bind lane_xbar lane_xbar_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_lane_xbar.sv
module tb_lane_xbar;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lbStrapN = 1'b0;
  logic lbLoad = 1'b0;
  logic [L-1:0] lbValue = '0;
  logic [L-1:0] rxA = '0, rxB = '0, sigA = '0, sigB = '0;
  logic [L-1:0] inDisA = '0, inDisB = '0, outDisA = '0, outDisB = '0;
  logic [L-1:0] pwrDnNA = '1, pwrDnNB = '1;
  logic [L-1:0] txA, txB, txEnA, txEnB, passThru;

  lane_xbar #(.LANES(L)) dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [L-1:0] a, b, ea, eb, pt;
  } outs_t;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  outs_t expQ[$];
  int dueQ[$];
  string tagQ[$];
  logic [L-1:0] lbModel;

  // staged stimulus
  logic nLoad;
  logic [L-1:0] nVal, nRxA, nRxB, nSigA, nSigB, nIdA, nIdB, nOdA, nOdB, nPdA, nPdB;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic outs_t model();
    outs_t o;
    for (int i = 0; i < L; i++) begin
      logic okA, okB, aFeedsB, srcOkB, srcBit;
      okA = nPdA[i] && !nIdA[i] && nSigA[i];
      okB = nPdB[i] && !nIdB[i] && nSigB[i];
      aFeedsB = !lbModel[i] && !nIdA[i];
      srcOkB = aFeedsB ? okA : okB;
      srcBit = aFeedsB ? nRxA[i] : nRxB[i];
      o.ea[i] = nPdA[i] && !nOdA[i] && okA;
      o.eb[i] = nPdB[i] && !nOdB[i] && srcOkB;
      o.a[i]  = o.ea[i] && nRxA[i];
      o.b[i]  = o.eb[i] && srcBit;
    end
    if (nLoad) lbModel = nVal;
    o.pt = lbModel;
    return o;
  endfunction

  task automatic compare(string tag, outs_t act, outs_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual a=%b b=%b ea=%b eb=%b pt=%b expected a=%b b=%b ea=%b eb=%b pt=%b",
               tag, act.a, act.b, act.ea, act.eb, act.pt,
               exp.a, exp.b, exp.ea, exp.eb, exp.pt);
    end
  endtask

  // driver: apply staged inputs, push the expected result due next edge
  task automatic drive(string tag);
    @(negedge clk);
    lbLoad = nLoad; lbValue = nVal; rxA = nRxA; rxB = nRxB;
    sigA = nSigA; sigB = nSigB; inDisA = nIdA; inDisB = nIdB;
    outDisA = nOdA; outDisB = nOdB; pwrDnNA = nPdA; pwrDnNB = nPdB;
    expQ.push_back(model());
    dueQ.push_back(cyc + 1);
    tagQ.push_back(tag);
    nLoad = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      outs_t act;
      act = '{a: txA, b: txB, ea: txEnA, eb: txEnB, pt: passThru};
      compare(tagQ[0], act, expQ[0]);
      void'(expQ.pop_front());
      void'(dueQ.pop_front());
      void'(tagQ.pop_front());
    end
  end

  task automatic idle();
    nLoad = 0; nVal = '0; nRxA = '0; nRxB = '0; nSigA = '1; nSigB = '1;
    nIdA = '0; nIdB = '0; nOdA = '0; nOdB = '0; nPdA = '1; nPdB = '1;
  endtask

  task automatic resetWith(logic strap, string tag);
    @(negedge clk);
    rstN = 1'b0; lbStrapN = strap; lbLoad = 1'b1; lbValue = ~{L{strap}};
    rxA = '1; rxB = '1; sigA = '1; sigB = '1;
    repeat (3) @(negedge clk);
    compare(tag, '{a: txA, b: txB, ea: txEnA, eb: txEnB, pt: passThru},
            '{a: '0, b: '0, ea: '0, eb: '0, pt: {L{strap}}});
    lbModel = {L{strap}};
    rstN = 1'b1; lbLoad = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    resetWith(1'b0, "R1 strap loopback");

    // R3: broadcast with lanes in loopback from the strap
    nRxA = 4'b1010; nRxB = 4'b0101; drive("R3 broadcast");
    nRxA = 4'b0110; nRxB = 4'b1111; drive("R3 broadcast");

    // R4: demux, A output off
    nOdA = 4'b1111; nRxA = 4'b1101; nRxB = 4'b0000; drive("R4 demux");
    idle();

    // R5: mux, A input off
    nIdA = 4'b1111; nRxA = 4'b1111; nRxB = 4'b1001; drive("R5 mux");
    idle();

    // R10: load pass-through on lanes 0 and 2; routing still loopback this step
    nLoad = 1; nVal = 4'b0101; nRxA = 4'b0011; nRxB = 4'b1100; drive("R10 load");
    nRxA = 4'b0011; nRxB = 4'b1100; drive("R10 new routing");

    // R12: mixed lanes, varied data
    nRxA = 4'b1001; nRxB = 4'b0110; drive("R12 mixed lanes");

    // R2: all lanes pass-through
    nLoad = 1; nVal = 4'b1111; drive("R10 load all");
    nRxA = 4'b1011; nRxB = 4'b0100; drive("R2 normal");
    nRxA = 4'b0100; nRxB = 4'b1011; drive("R2 normal");

    // R7: squelch
    nRxA = '1; nRxB = '1; nSigA = 4'b0011; nSigB = 4'b1010; drive("R7 squelch");
    idle();

    // R8: input disable in pass-through
    nRxA = '1; nRxB = '1; nIdA = 4'b1000; nIdB = 4'b0001; drive("R8 input off");
    idle();

    // R6: output disable
    nRxA = '1; nRxB = '1; nOdA = 4'b0110; nOdB = 4'b1001; drive("R6 output off");
    idle();

    // R9: power down, pass-through and in loopback as a source
    nRxA = '1; nRxB = '1; nPdA = 4'b1100; nPdB = 4'b0101; drive("R9 power down");
    nLoad = 1; nVal = 4'b0000; nRxA = '1; nRxB = '1; drive("R10 load loop");
    nRxA = '1; nRxB = '1; nPdA = 4'b0011; drive("R9 source powered down");
    idle();

    // R11: data zero whenever enable low, via random sweep
    for (int k = 0; k < 80; k++) begin
      nLoad = ($urandom % 8 == 0); nVal = 4'($urandom);
      nRxA = 4'($urandom); nRxB = 4'($urandom);
      nSigA = 4'($urandom) | 4'($urandom); nSigB = 4'($urandom) | 4'($urandom);
      nIdA = 4'($urandom) & 4'($urandom); nIdB = 4'($urandom) & 4'($urandom);
      nOdA = 4'($urandom) & 4'($urandom); nOdB = 4'($urandom) & 4'($urandom);
      nPdA = 4'($urandom) | 4'($urandom); nPdB = 4'($urandom) | 4'($urandom);
      drive((k % 2) ? "R11 random" : "R12 random");
    end
    idle();
    drive("R2 settle");
    repeat (3) @(negedge clk);

    resetWith(1'b1, "R1 strap pass-through");
    nRxA = 4'b0110; nRxB = 4'b1001; drive("R2 after strap");
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule